// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block drives a successive-approximation converter core from a single control register. It divides the system clock into a conversion tick and picks the input channel from an eight-bit mask. A conversion starts in one of three ways: at once when the register is written, on a chosen edge of an external trigger, or continuously in burst mode, which cycles through the enabled channels. Each finished conversion is written to a data register together with its channel number, a completion flag and an overrun flag. Reading that register clears both flags.

The converter core is a behavioural stub. It counts conversion ticks, then returns the digital code presented on `ain_codes` for the channel it latched, with the low bits masked off to match the chosen resolution. Writing the control register cancels any conversion in progress and applies the new settings at once.

Top module: `adc_scan_seq`

## Requirements
- R1: The control register has DIV at bits [15:8]. `conv_tick` pulses once every DIV+1 clock cycles while the block is powered. A conversion of N ticks started by a register write sets `rd_done` N*(DIV+1) cycles after that write edge.
- R2: When bit 20 (burst) is 0, every conversion lasts 11 ticks and returns the full 10-bit code of its channel.
- R3: When burst is 1, the field at bits [23:21] (value c, 0 to 7) makes each conversion last 11-c ticks and return 10-c significant bits, with the low c result bits forced to zero.
- R4: SEL at bits [7:0] is a channel mask. A software start converts the lowest-numbered selected channel. A mask of zero produces no conversion.
- R5: A start field (bits [18:16]) of 2 to 7 starts a conversion on an edge of `trig`. Bit 19 set to 1 selects the rising edge; set to 0 it selects the falling edge. The opposite edge starts nothing.
- R6: A start field of 0 (outside burst) starts nothing. A value of 1 starts a conversion on the clock edge of the register write.
- R7: While bit 24 (power enable) is 0, `conv_tick` stays low and no conversion runs. A write that clears the bit cancels any conversion in progress.
- R8: Burst mode converts the selected channels in ascending order, wraps from the highest back to the lowest, skips clear mask bits, and runs back to back with no idle tick.
- R9: On completion, `rd_result`, `rd_chan` and `rd_done` take the new code, its channel and 1. A one-cycle `rd_ack` clears `rd_done` and `rd_overrun`.
- R10: `rd_overrun` is set when a conversion completes while `rd_done` is still 1 and `rd_ack` is low. If a completion and `rd_ack` fall in the same cycle, the result is `rd_done`=1 and `rd_overrun`=0.
- R11: A control write during a conversion abandons it. Only the conversion defined by the new settings can complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 25 | Control word: sel, div, start, edge, burst, clks, power |
| trig | input | 1 | External start trigger |
| ain_codes | input | 80 | Ten-bit code for each of the eight channels, channel 0 in the low bits |
| rd_ack | input | 1 | Data register read strobe |
| rd_result | output | 10 | Last conversion code, left aligned |
| rd_chan | output | 3 | Channel of the last conversion |
| rd_done | output | 1 | A result is waiting to be read |
| rd_overrun | output | 1 | An unread result was overwritten |
| conv_tick | output | 1 | Divided conversion clock enable |
| conv_busy | output | 1 | Converter core is converting |

## Verification
Two events can coincide at the data register: a read acknowledge and the completion of a new conversion. The bench triggers the collision by starting a software conversion with DIV=0 while an unread result is held. It then raises `rd_ack` in exactly the cycle before the eleventh tick edge. A correct design shows DONE still set, OVERRUN clear and the new channel. The same sequence without the acknowledge must set OVERRUN, and a burst run left unread must set it as well.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int NCH  = 8;
    localparam int RES  = 10;
    localparam int DIVW = 8;
    localparam int CHW  = $clog2(NCH);
    localparam int CNTW = 4;
    localparam int SW_LEN = 11;

    localparam logic [2:0] ST_NONE = 3'd0;
    localparam logic [2:0] ST_NOW  = 3'd1;
    localparam logic [2:0] ST_TRIG = 3'd2;

    typedef struct packed {
        logic            pwr_en;
        logic [2:0]      clks;
        logic            burst;
        logic            trig_rise;
        logic [2:0]      start_mode;
        logic [DIVW-1:0] div;
        logic [NCH-1:0]  sel;
    } ctl_t;

    localparam int CTLW = $bits(ctl_t);

    typedef struct packed {
        logic [CHW-1:0] ch;
        logic [RES-1:0] val;
    } sample_t;

    function automatic logic [CNTW-1:0] conv_len(logic burst, logic [2:0] clks);
        logic [CNTW-1:0] n;
        n = CNTW'(SW_LEN);
        if (burst) n = n - {1'b0, clks};
        return n;
    endfunction

    function automatic logic [RES-1:0] res_mask(logic burst, logic [2:0] clks);
        logic [RES-1:0] m;
        m = '1;
        if (burst) m = m << clks;
        return m;
    endfunction

    // first selected channel strictly after cur, wrapping around
    function automatic logic [CHW-1:0] next_ch(logic [NCH-1:0] sel, logic [CHW-1:0] cur);
        logic [CHW-1:0] r;
        logic           found;
        r = cur;
        found = 1'b0;
        for (int i = 1; i <= NCH; i++) begin
            logic [CHW-1:0] c;
            c = CHW'((int'(cur) + i) % NCH);
            if (!found && sel[c]) begin
                r = c;
                found = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
    import adc_scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            restart,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt <= '0;
        else if (tick)              cnt <= '0;
        else                        cnt <= cnt + DIVW'(1);
    end

    // consecutive ticks only possible with a divide of one
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        tick && $past(tick) |-> div == '0);

endmodule

// File: rtl/adc_core_stub.sv
module adc_core_stub
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic              abort,
    input  logic [CHW-1:0]    start_ch,
    input  logic [CNTW-1:0]   start_len,
    input  logic [RES-1:0]    start_mask,
    input  logic [NCH*RES-1:0] ain,
    output logic              busy,
    output logic              fin,
    output sample_t           fin_s
);
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] len;
    logic [CHW-1:0]  ch;
    logic [RES-1:0]  mask;

    assign fin       = busy && tick && (cnt == len - CNTW'(1));
    assign fin_s.ch  = ch;
    assign fin_s.val = ain[ch*RES +: RES] & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            len  <= '0;
            ch   <= '0;
            mask <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            len  <= start_len;
            ch   <= start_ch;
            mask <= start_mask;
        end else if (abort || fin) begin
            busy <= 1'b0;
        end else if (busy && tick) begin
            cnt  <= cnt + CNTW'(1);
        end
    end

    assert_count_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt < len);

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
    import adc_scan_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           fin,
    input  sample_t        fin_s,
    input  logic           ack,
    output logic [RES-1:0] result,
    output logic [CHW-1:0] chan,
    output logic           done,
    output logic           overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            chan    <= '0;
            done    <= 1'b0;
            overrun <= 1'b0;
        end else if (fin) begin
            result  <= fin_s.val;
            chan    <= fin_s.ch;
            done    <= 1'b1;
            overrun <= done && !ack;
        end else if (ack) begin
            done    <= 1'b0;
            overrun <= 1'b0;
        end
    end

    assert_overrun_implies_done_R10: assert property (@(posedge clk) disable iff (rst)
        overrun |-> done);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_we,
    input  logic [CTLW-1:0]     ctl_wdata,
    input  logic                trig,
    input  logic [NCH*RES-1:0]  ain_codes,
    input  logic                rd_ack,
    output logic [RES-1:0]      rd_result,
    output logic [CHW-1:0]      rd_chan,
    output logic                rd_done,
    output logic                rd_overrun,
    output logic                conv_tick,
    output logic                conv_busy
);
    ctl_t    ctl, wctl, cfg;
    logic    trig_q, edge_hit;
    logic    wr_start, ed_start, chain, core_start;
    logic    fin;
    sample_t fin_s;
    logic [CHW-1:0] start_ch;

    assign wctl = ctl_t'(ctl_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig;
            if (ctl_we) ctl <= wctl;
        end
    end

    assign edge_hit = ctl.trig_rise ? (trig && !trig_q) : (!trig && trig_q);

    assign wr_start = ctl_we && wctl.pwr_en && (wctl.sel != '0)
                      && (wctl.burst || wctl.start_mode == ST_NOW);
    assign ed_start = !ctl_we && !conv_busy && ctl.pwr_en && !ctl.burst
                      && (ctl.start_mode >= ST_TRIG) && (ctl.sel != '0) && edge_hit;
    assign chain    = !ctl_we && fin && ctl.burst && ctl.pwr_en;
    assign core_start = wr_start || ed_start || chain;

    assign cfg      = ctl_we ? wctl : ctl;
    assign start_ch = chain ? next_ch(ctl.sel, fin_s.ch)
                            : next_ch(cfg.sel, CHW'(NCH-1));

    adc_clk_div u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl.pwr_en),
        .restart (ctl_we),
        .div     (ctl.div),
        .tick    (conv_tick)
    );

    adc_core_stub u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (conv_tick),
        .start      (core_start),
        .abort      (ctl_we),
        .start_ch   (start_ch),
        .start_len  (conv_len(cfg.burst, cfg.clks)),
        .start_mask (res_mask(cfg.burst, cfg.clks)),
        .ain        (ain_codes),
        .busy       (conv_busy),
        .fin        (fin),
        .fin_s      (fin_s)
    );

    adc_result_reg u_res (
        .clk     (clk),
        .rst     (rst),
        .fin     (fin),
        .fin_s   (fin_s),
        .ack     (rd_ack),
        .result  (rd_result),
        .chan    (rd_chan),
        .done    (rd_done),
        .overrun (rd_overrun)
    );

    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        !ctl.pwr_en |-> !conv_busy);

    assert_finish_needs_power_R7: assert property (@(posedge clk) disable iff (rst)
        fin |-> ctl.pwr_en);

    assert_burst_channel_selected_R8: assert property (@(posedge clk) disable iff (rst)
        fin && ctl.burst |-> ctl.sel[fin_s.ch]);

endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [24:0] ctl_wdata = '0;
    logic        trig = 1'b0;
    logic [79:0] ain_codes;
    logic        rd_ack = 1'b0;
    logic [9:0]  rd_result;
    logic [2:0]  rd_chan;
    logic        rd_done, rd_overrun, conv_tick, conv_busy;
    logic [9:0]  ain [8];

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb for (int i = 0; i < 8; i++) ain_codes[i*10 +: 10] = ain[i];

    adc_scan_seq uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .trig(trig),
        .ain_codes(ain_codes), .rd_ack(rd_ack), .rd_result(rd_result), .rd_chan(rd_chan),
        .rd_done(rd_done), .rd_overrun(rd_overrun), .conv_tick(conv_tick), .conv_busy(conv_busy)
    );

    function automatic logic [24:0] mk(input logic [7:0] sel, input logic [7:0] dv,
        input logic [2:0] st, input logic ed, input logic bu, input logic [2:0] ck, input logic pw);
        return {pw, ck, bu, ed, st, dv, sel};
    endfunction

    function automatic int low_ch(input logic [7:0] sel);
        for (int i = 0; i < 8; i++) if (sel[i]) return i;
        return -1;
    endfunction

    function automatic int nxt(input logic [7:0] sel, input int cur);
        for (int i = 1; i <= 8; i++) if (sel[(cur + i) % 8]) return (cur + i) % 8;
        return cur;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wcfg(input logic [24:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
    endtask

    task automatic wait_done(input int limit, output int cyc);
        cyc = 0;
        while (!rd_done && cyc < limit) begin
            @(negedge clk); cyc++;
        end
    endtask

    // watch n cycles; report whether done or a tick appeared
    task automatic quiet(input int n, output bit saw_done, output int ticks);
        saw_done = 0; ticks = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rd_done) saw_done = 1;
            if (conv_tick) ticks++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int c, tk, last, exp_ch;
        bit sd;
        logic [7:0] sel;
        logic [7:0] dv;
        logic [2:0] ck;
        void'($urandom(32'h5eed_adc1));
        for (int i = 0; i < 8; i++) ain[i] = 10'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_done == 0 && rd_overrun == 0 && rd_result == 0 && !conv_busy, "R9 reset", rd_done, 0);

        // R1 tick spacing
        wcfg(mk(8'h00, 8'd2, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1));
        last = -1; c = 0; tk = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (conv_tick) begin
                if (last >= 0) begin
                    tk++;
                    if (i - last != 3) c++;
                end
                last = i;
            end
        end
        chk(c == 0 && tk >= 8, "R1 tick period", c, 0);

        // R1 R2 R4 R9 software starts, random
        for (int it = 0; it < 6; it++) begin
            dv  = 8'($urandom % 4);
            sel = 8'($urandom % 255 + 1);
            ck  = 3'($urandom);
            wcfg(mk(sel, dv, 3'd1, 1'b0, 1'b0, ck, 1'b1));
            wait_done(200, c);
            chk(c == 11 * (int'(dv) + 1), "R1 conversion time", c, 11 * (int'(dv) + 1));
            chk(rd_result == ain[low_ch(sel)], "R2 full code", rd_result, ain[low_ch(sel)]);
            chk(int'(rd_chan) == low_ch(sel), "R4 lowest channel", rd_chan, low_ch(sel));
            ack();
            chk(!rd_done && !rd_overrun, "R9 ack clears", rd_done, 0);
        end

        // R3 R8 burst scans
        for (int it = 0; it < 4; it++) begin
            if (it == 0) begin sel = 8'b1000_0100; ck = 3'd7; dv = 8'd0; end
            else begin
                sel = 8'($urandom % 255 + 1);
                ck  = 3'($urandom);
                dv  = 8'($urandom % 3);
            end
            wcfg(mk(sel, dv, 3'd0, 1'b0, 1'b1, ck, 1'b1));
            exp_ch = low_ch(sel);
            for (int k = 0; k < 6; k++) begin
                wait_done(300, c);
                if (k == 0)
                    chk(c == (11 - int'(ck)) * (int'(dv) + 1), "R3 burst length", c,
                        (11 - int'(ck)) * (int'(dv) + 1));
                chk(int'(rd_chan) == exp_ch, "R8 scan order", rd_chan, exp_ch);
                chk(rd_result == (ain[exp_ch] & (10'h3FF << ck)), "R3 resolution", rd_result,
                    ain[exp_ch] & (10'h3FF << ck));
                ack();
                exp_ch = nxt(sel, exp_ch);
            end
            wcfg(mk(8'h00, 8'd0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0));
            ack();
        end

        // R10 burst overrun, R8 back to back
        wcfg(mk(8'h03, 8'd1, 3'd0, 1'b0, 1'b1, 3'd0, 1'b1));
        wait_done(100, c);
        repeat (22) @(negedge clk);
        chk(rd_overrun == 1 && rd_done == 1, "R10 burst overrun", rd_overrun, 1);
        chk(rd_chan == 3'd1, "R8 next without gap", rd_chan, 1);
        ack();
        chk(!rd_overrun && !rd_done, "R9 ack clears overrun", rd_overrun, 0);
        wcfg(mk(8'h00, 8'd0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0));
        ack();

        // R10 ack and completion in the same cycle
        wcfg(mk(8'h04, 8'd0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1));
        wait_done(50, c);
        wcfg(mk(8'h20, 8'd0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1));
        repeat (10) @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
        chk(rd_done == 1 && rd_overrun == 0, "R10 ack with completion", rd_overrun, 0);
        chk(rd_chan == 3'd5, "R10 new channel kept", rd_chan, 5);
        wcfg(mk(8'h20, 8'd0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1));
        repeat (11) @(negedge clk);
        chk(rd_overrun == 1, "R10 overrun without ack", rd_overrun, 1);
        ack();

        // R5 rising trigger
        wcfg(mk(8'h10, 8'd0, 3'd2, 1'b1, 1'b0, 3'd0, 1'b1));
        @(negedge clk); trig = 1'b1;
        wait_done(40, c);
        chk(c == 12 && rd_chan == 3'd4, "R5 rising start", c, 12);
        ack();
        // R5 falling trigger: rising edge ignored, falling starts
        wcfg(mk(8'h10, 8'd0, 3'd5, 1'b0, 1'b0, 3'd0, 1'b1));
        quiet(20, sd, tk);
        chk(!sd, "R5 no edge no start", sd, 0);
        trig = 1'b0;
        wait_done(40, c);
        chk(c == 12, "R5 falling start", c, 12);
        ack();
        trig = 1'b1;
        quiet(25, sd, tk);
        chk(!sd, "R5 opposite edge ignored", sd, 0);
        wcfg(mk(8'h00, 8'd0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0));
        trig = 1'b0;

        // R6 start none
        wcfg(mk(8'hFF, 8'd0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1));
        quiet(40, sd, tk);
        chk(!sd, "R6 no start", sd, 0);
        // R4 empty mask
        wcfg(mk(8'h00, 8'd0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1));
        quiet(40, sd, tk);
        chk(!sd, "R4 empty mask", sd, 0);
        // R7 powered down
        wcfg(mk(8'hFF, 8'd0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b0));
        quiet(40, sd, tk);
        chk(!sd && tk == 0, "R7 power down idle", tk, 0);
        wcfg(mk(8'h01, 8'd0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1));
        repeat (5) @(negedge clk);
        wcfg(mk(8'h01, 8'd0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0));
        quiet(40, sd, tk);
        chk(!sd, "R7 power off aborts", sd, 0);

        // R11 rewrite mid conversion
        wcfg(mk(8'h01, 8'd3, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1));
        repeat (10) @(negedge clk);
        wcfg(mk(8'h40, 8'd0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1));
        wait_done(100, c);
        chk(c == 11 && rd_chan == 3'd6, "R11 restart on write", c, 11);
        ack();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule